// File: doc/BRIEF.md
# Debug strap latch and pin mux

This block decides, once per power-on, whether two shared general-purpose pads are handed over to a serial wire debug port. After the active-low power-on reset is released, a delay counter runs for a fixed time, nominally 250 µs. When the count expires, the configuration strap is sampled through a two-flop synchronizer and the result is locked. The locked mode holds until the next reset. The strap pin itself is then free for firmware, and its raw level is always passed through to functional logic.

When the captured strap is high, the block enters debug mode. The first pad becomes the SWD clock input toward the debug port, with its output driver forced off. The second pad carries the bidirectional SWD data line, and the debug port's drive-enable controls that pad's output enable. When the strap is low, both pads stay with their functional owners; this is the default. Before the capture completes, the pads stay in the functional routing whatever level the strap has, so nothing glitches during the sampling window.

The control is a four-state machine:
- `ST_SETTLE` counts cycles after reset.
  - `SETTLE->SAMPLE` when the count reaches its last value.
- `ST_SAMPLE` takes the synchronized strap for one cycle.
  - `SAMPLE->DEBUG` on a high strap.
  - `SAMPLE->FUNC` on a low strap.
- `ST_FUNC` and `ST_DEBUG` are terminal and are left only by reset.

Top module: `dbg_strap_mux`

## Requirements
- R1: While reset is asserted and right after it, `debug_mode` and `latch_done` are 0 and both pads use the functional routing.
- R2: With WAIT = CLK_MHZ*DELAY_US, `debug_mode` and `latch_done` take their captured values on the (WAIT+1)-th rising clock edge after reset release. They are still 0 after the WAIT-th edge.
- R3: The captured value is the strap level present before rising edge WAIT-1, because the strap is delayed by two synchronizer flops. A level of 1 selects debug mode and a level of 0 selects functional mode.
- R4: `latch_done` is high for exactly one cycle per reset.
- R5: After the capture, changes on `strap_pin` have no effect on `debug_mode` or on the pad routing until the next reset.
- R6: `strap_fn_in` always equals `strap_pin`, in every state.
- R7: In functional mode:
  - `padN_o` equals `funcN_o` and `padN_oe` equals `funcN_oe`.
  - `funcN_i` equals `padN_i`.
  - `dp_swclk` and `dp_swdio_i` are 0.
- R8: In debug mode:
  - `pad0_oe` and `pad0_o` are 0.
  - `dp_swclk` equals `pad0_i`.
  - `func0_i` is 0.
- R9: In debug mode:
  - `pad1_o` equals `dp_swdio_o` and `pad1_oe` equals `dp_swdio_oe`.
  - `dp_swdio_i` equals `pad1_i`.
  - `func1_i` is 0.
  - The functional pad-1 drivers are ignored.
- R10: Before the capture completes, the pads keep the functional routing even when the strap is high.
- R11: A new reset clears a captured debug mode at once and restarts the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| strap_pin | input | 1 | Raw configuration strap |
| strap_fn_in | output | 1 | Strap level passed to functional logic |
| pad0_i | input | 1 | Shared pad 0 input buffer |
| pad0_o | output | 1 | Shared pad 0 output value |
| pad0_oe | output | 1 | Shared pad 0 output enable |
| func0_o | input | 1 | Functional output for pad 0 |
| func0_oe | input | 1 | Functional output enable for pad 0 |
| func0_i | output | 1 | Pad 0 input seen by functional logic |
| pad1_i | input | 1 | Shared pad 1 input buffer |
| pad1_o | output | 1 | Shared pad 1 output value |
| pad1_oe | output | 1 | Shared pad 1 output enable |
| func1_o | input | 1 | Functional output for pad 1 |
| func1_oe | input | 1 | Functional output enable for pad 1 |
| func1_i | output | 1 | Pad 1 input seen by functional logic |
| dp_swclk | output | 1 | SWD clock toward the debug port |
| dp_swdio_i | output | 1 | SWD data toward the debug port |
| dp_swdio_o | input | 1 | SWD data driven by the debug port |
| dp_swdio_oe | input | 1 | SWD drive enable from the debug port |
| debug_mode | output | 1 | Captured debug-mode status |
| latch_done | output | 1 | One-cycle strobe when the capture completes |

## Verification
The bench builds the block with CLK_MHZ=2 and DELAY_US=5, so the sampling delay is 10 cycles instead of 25000. This makes it cheap to reboot the block many times and to count every edge up to the capture. The short window brings within reach:
- the exact capture edge;
- both sides of the synchronizer boundary, with the strap raised one cycle before and one cycle after the last edge that still counts;
- strap changes after the capture;
- a reset that arrives in debug mode.

Each vector reboots the block with its own strap level, so both pad routings are exercised with several pad and debug-port patterns.

// File: rtl/dbg_strap_pkg.sv
package dbg_strap_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_FUNC   = 2'd2,
        ST_DEBUG  = 2'd3
    } strap_state_e;

    function automatic int unsigned wait_cycles(input int unsigned mhz, input int unsigned us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import dbg_strap_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_s,
    output logic debug_mode,
    output logic latch_done
);
    localparam int unsigned CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    strap_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          mode_q, done_q;

    // state register and delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE: if (cnt_q == LAST) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = strap_s ? ST_DEBUG : ST_FUNC;
            ST_FUNC:   state_d = ST_FUNC;
            ST_DEBUG:  state_d = ST_DEBUG;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_SAMPLE);
            if (state_q == ST_SAMPLE) mode_q <= strap_s;
        end
    end

    assign debug_mode = mode_q;
    assign latch_done = done_q;
endmodule

// File: rtl/pad_route.sv
module pad_route (
    input  logic dbg_en,
    input  logic pad0_i,
    output logic pad0_o,
    output logic pad0_oe,
    input  logic func0_o,
    input  logic func0_oe,
    output logic func0_i,
    input  logic pad1_i,
    output logic pad1_o,
    output logic pad1_oe,
    input  logic func1_o,
    input  logic func1_oe,
    output logic func1_i,
    output logic dp_swclk,
    output logic dp_swdio_i,
    input  logic dp_swdio_o,
    input  logic dp_swdio_oe
);
    always_comb begin
        if (dbg_en) begin
            pad0_o     = 1'b0;
            pad0_oe    = 1'b0;
            func0_i    = 1'b0;
            dp_swclk   = pad0_i;
            pad1_o     = dp_swdio_o;
            pad1_oe    = dp_swdio_oe;
            func1_i    = 1'b0;
            dp_swdio_i = pad1_i;
        end else begin
            pad0_o     = func0_o;
            pad0_oe    = func0_oe;
            func0_i    = pad0_i;
            dp_swclk   = 1'b0;
            pad1_o     = func1_o;
            pad1_oe    = func1_oe;
            func1_i    = pad1_i;
            dp_swdio_i = 1'b0;
        end
    end
endmodule

// File: rtl/dbg_strap_mux.sv
module dbg_strap_mux #(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned DELAY_US    = 250,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_pin,
    output logic strap_fn_in,
    input  logic pad0_i,
    output logic pad0_o,
    output logic pad0_oe,
    input  logic func0_o,
    input  logic func0_oe,
    output logic func0_i,
    input  logic pad1_i,
    output logic pad1_o,
    output logic pad1_oe,
    input  logic func1_o,
    input  logic func1_oe,
    output logic func1_i,
    output logic dp_swclk,
    output logic dp_swdio_i,
    input  logic dp_swdio_o,
    input  logic dp_swdio_oe,
    output logic debug_mode,
    output logic latch_done
);
    localparam int unsigned WAIT_CYCLES = dbg_strap_pkg::wait_cycles(CLK_MHZ, DELAY_US);

    logic strap_s;

    assign strap_fn_in = strap_pin;

    strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(strap_pin), .q(strap_s)
    );

    strap_capture #(.WAIT_CYCLES(WAIT_CYCLES)) u_cap (
        .clk(clk), .rst_n(rst_n), .strap_s(strap_s),
        .debug_mode(debug_mode), .latch_done(latch_done)
    );

    pad_route u_route (
        .dbg_en(debug_mode),
        .pad0_i(pad0_i), .pad0_o(pad0_o), .pad0_oe(pad0_oe),
        .func0_o(func0_o), .func0_oe(func0_oe), .func0_i(func0_i),
        .pad1_i(pad1_i), .pad1_o(pad1_o), .pad1_oe(pad1_oe),
        .func1_o(func1_o), .func1_oe(func1_oe), .func1_i(func1_i),
        .dp_swclk(dp_swclk), .dp_swdio_i(dp_swdio_i),
        .dp_swdio_o(dp_swdio_o), .dp_swdio_oe(dp_swdio_oe)
    );
endmodule

// File: rtl/dbg_strap_chk.sv
module dbg_strap_chk #(
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned DELAY_US = 250
) (
    input logic clk,
    input logic rst_n,
    input logic strap_pin,
    input logic strap_fn_in,
    input logic pad0_i,
    input logic pad0_o,
    input logic pad0_oe,
    input logic func0_o,
    input logic func0_oe,
    input logic func0_i,
    input logic pad1_i,
    input logic pad1_o,
    input logic pad1_oe,
    input logic func1_o,
    input logic func1_oe,
    input logic func1_i,
    input logic dp_swclk,
    input logic dp_swdio_i,
    input logic dp_swdio_o,
    input logic dp_swdio_oe,
    input logic debug_mode,
    input logic latch_done
);
    localparam logic [31:0] DONE_AT = 32'(CLK_MHZ * DELAY_US + 1);

    logic [31:0] cyc_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (cyc_q != '1) cyc_q <= cyc_q + 1'b1;
            if (latch_done)  seen_q <= 1'b1;
        end
    end

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_done |-> (cyc_q == DONE_AT));

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_done |=> !latch_done);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_done |-> $stable(debug_mode));

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strap_fn_in == strap_pin);

    p_func_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_mode |-> (pad0_o == func0_o && pad0_oe == func0_oe && func0_i == pad0_i
                         && pad1_o == func1_o && pad1_oe == func1_oe && func1_i == pad1_i
                         && !dp_swclk && !dp_swdio_i));

    p_clkpad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> (!pad0_oe && !pad0_o && dp_swclk == pad0_i && !func0_i));

    p_datpad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> (pad1_o == dp_swdio_o && pad1_oe == dp_swdio_oe
                        && dp_swdio_i == pad1_i && !func1_i));

    p_no_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> (seen_q || latch_done));
endmodule

bind dbg_strap_mux dbg_strap_chk #(.CLK_MHZ(CLK_MHZ), .DELAY_US(DELAY_US)) u_chk (.*);

// File: tb/dbg_strap_mux_tb.sv
module dbg_strap_mux_tb;
    localparam int MHZ  = 2;
    localparam int US   = 5;
    localparam int WAIT = MHZ * US;

    typedef struct packed {
        logic strap, f0o, f0oe, f1o, f1oe, p0i, p1i, dpo, dpoe;
    } vec_t;

    localparam vec_t VECS [6] = '{
        9'b0_1_1_0_1_1_0_1_1,
        9'b0_0_0_1_1_0_1_0_0,
        9'b1_1_1_1_1_1_0_1_1,
        9'b1_0_1_0_1_0_1_0_1,
        9'b1_1_0_1_0_1_1_1_0,
        9'b0_1_0_0_1_0_0_1_1
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_pin = 1'b0;
    logic pad0_i = 1'b0, func0_o = 1'b0, func0_oe = 1'b0;
    logic pad1_i = 1'b0, func1_o = 1'b0, func1_oe = 1'b0;
    logic dp_swdio_o = 1'b0, dp_swdio_oe = 1'b0;
    logic strap_fn_in, pad0_o, pad0_oe, func0_i, pad1_o, pad1_oe, func1_i;
    logic dp_swclk, dp_swdio_i, debug_mode, latch_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dbg_strap_mux #(.CLK_MHZ(MHZ), .DELAY_US(US)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected pad bundle {pad0_o,pad0_oe,func0_i,dp_swclk,pad1_o,pad1_oe,func1_i,dp_swdio_i}
    function automatic logic [7:0] expect_pads(input logic dbg, input vec_t v);
        if (dbg) return {1'b0, 1'b0, 1'b0, v.p0i, v.dpo, v.dpoe, 1'b0, v.p1i};
        return {v.f0o, v.f0oe, v.p0i, 1'b0, v.f1o, v.f1oe, v.p1i, 1'b0};
    endfunction

    function automatic logic [7:0] seen_pads();
        return {pad0_o, pad0_oe, func0_i, dp_swclk, pad1_o, pad1_oe, func1_i, dp_swdio_i};
    endfunction

    task automatic apply(input vec_t v);
        func0_o = v.f0o; func0_oe = v.f0oe; func1_o = v.f1o; func1_oe = v.f1oe;
        pad0_i = v.p0i; pad1_i = v.p1i; dp_swdio_o = v.dpo; dp_swdio_oe = v.dpoe;
    endtask

    // Reset, then count edges to the capture; raise_at>0 raises the strap after that edge.
    task automatic boot(input logic strap0, input int raise_at, input logic exp_mode);
        @(negedge clk);
        rst_n = 1'b0;
        strap_pin = strap0;
        repeat (2) @(negedge clk);
        check("R1 mode in reset", {31'd0, debug_mode}, 0);
        check("R1 done in reset", {31'd0, latch_done}, 0);
        rst_n = 1'b1;
        for (int i = 1; i <= WAIT + 1; i++) begin
            @(negedge clk);
            if (i == raise_at) strap_pin = 1'b1;
            if (i == WAIT) begin
                check("R2 not before edge", {30'd0, debug_mode, latch_done}, 0);
            end
        end
        check("R2/R3 captured mode", {31'd0, debug_mode}, {31'd0, exp_mode});
        check("R2 done strobe", {31'd0, latch_done}, 1);
        @(negedge clk);
        check("R4 strobe one cycle", {31'd0, latch_done}, 0);
    endtask

    initial begin
        vec_t w;
        // table walk: each vector boots with its own strap and checks routing
        for (int k = 0; k < 6; k++) begin
            boot(VECS[k].strap, 0, VECS[k].strap);
            apply(VECS[k]);
            #2;
            check(VECS[k].strap ? "R8/R9 debug routing" : "R7 functional routing",
                  {24'd0, seen_pads()}, {24'd0, expect_pads(VECS[k].strap, VECS[k])});
        end

        // R3 synchronizer boundary: raised before edge WAIT-1 counts, after it does not
        boot(1'b0, WAIT - 2, 1'b1);
        boot(1'b0, WAIT - 1, 1'b0);

        // R10: strap high but pads still functional during the window
        @(negedge clk);
        rst_n = 1'b0;
        strap_pin = 1'b1;
        w = 9'b1_1_1_0_1_1_1_0_0;
        apply(w);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (WAIT / 2) @(negedge clk);
        check("R10 functional in window", {24'd0, seen_pads()}, {24'd0, expect_pads(1'b0, w)});
        repeat (WAIT) @(negedge clk);
        check("R10 debug after capture", {31'd0, debug_mode}, 1);

        // R5/R6: strap toggles after the capture are ignored, raw passes through
        strap_pin = 1'b0;
        #1;
        check("R6 passthrough low", {31'd0, strap_fn_in}, 0);
        repeat (20) @(negedge clk);
        check("R5 held debug", {31'd0, debug_mode}, 1);
        check("R5 routing held", {24'd0, seen_pads()}, {24'd0, expect_pads(1'b1, w)});
        strap_pin = 1'b1;
        #1;
        check("R6 passthrough high", {31'd0, strap_fn_in}, 1);

        // R9: functional pad-1 drivers ignored in debug mode
        func1_o = 1'b0; func1_oe = 1'b0;
        #1;
        check("R9 func1 ignored", {30'd0, pad1_o, pad1_oe}, {30'd0, w.dpo, w.dpoe});

        // R11: reset clears debug mode at once
        rst_n = 1'b0;
        #1;
        check("R11 reset clears", {31'd0, debug_mode}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        strap_pin = 1'b0;
        repeat (WAIT + 1) @(negedge clk);
        check("R11 rearmed capture", {30'd0, debug_mode, latch_done}, 2'b01);

        // R5: functional capture ignores later strap high
        strap_pin = 1'b1;
        repeat (15) @(negedge clk);
        check("R5 held functional", {31'd0, debug_mode}, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule